// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processor cores share through one register bus. Every bus access carries the index of the core that issued it. A core takes a semaphore in one of two ways. It can write a lock request and then read the register back to see whether it won. It can also read a separate lock-on-read alias, which takes the semaphore in that single access. A taken semaphore records its owning core and a process number. The owner frees it with a matching release write. A bulk-clear register, guarded by a programmable key, frees every semaphore held by one named core at once.

Each core has its own notification path made of an enable register, a raw status register, a masked status view and a write-one-to-clear register. When a semaphore goes from taken to free, the other cores see a status bit. Each core's interrupt pin is raised from its masked status.

The request side is a valid/ready channel. `req_ready` is tied high, so the bank accepts one access on every cycle that `req_valid` is high. The response side has only a valid strobe and no back-pressure: the requester must take `rsp_rdata` in the cycle that `rsp_valid` is high.

Top module: `hsem_unit`

## Requirements
- R1: After reset, every semaphore reads 0, every enable and raw status register reads 0, the key register reads 0, and all `irq` bits are low.
- R2: A write to word address i (0x00 to N_SEM-1) with bit 31 set takes a free semaphore i. The owner becomes the issuing core and the process number becomes wdata[7:0]. The semaphore word then reads back as bit 31 = 1, bits 11:8 = owning core and bits 7:0 = process, with all other bits 0.
- R3: A lock attempt on a semaphore that is already taken, whether by a write or by a lock-on-read, leaves that semaphore's word unchanged.
- R4: A read of alias address 0x20+i takes a free semaphore i for the issuing core with process 0, and returns 0x8000_0000 | core<<8. If the semaphore is already taken, the read returns the current semaphore word.
- R5: A write to semaphore i with bit 31 clear frees it only when the issuing core and wdata[7:0] both match the owner. Any other release is ignored. A free semaphore reads 0.
- R6: The key register at 0x7F keeps wdata[15:0] on a write and reads it back with bits 31:16 equal to 0.
- R7: A write to 0x7F-1 (0x7E) whose bits 31:16 equal the key frees every semaphore owned by the core given in bits 11:8. When the key does not match, the write has no effect.
- R8: When a semaphore goes from taken to free, by release or by bulk clear, bit i is set in the raw status of every core except the owner. Core c's registers start at 0x40+4c: +0 is enable, +1 is clear (writing 1 clears that raw bit; the register reads 0), +2 is raw status and +3 is masked status.
- R9: Masked status equals raw status AND enable. `irq[c]` is high exactly when core c's masked status is nonzero.
- R10: `req_ready` is always 1. Every accepted read produces `rsp_valid` and its data on the next cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Always high; one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_core | input | CIDX_W (1) | Index of the issuing core |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | N_CORES (2) | Per-core semaphore-freed interrupt |

## Verification
The assertions assume that `req_core` always names an existing core and that inputs change only away from the active clock edge. Under those assumptions, a taken semaphore can leave the taken state only through a write access, and a free event always leaves a status bit with every core other than the owner. The bench drives every access on the falling edge. It only ever uses core indices 0 and 1 and holds each request for exactly one cycle. Every read response is sampled on the falling edge after the accepting edge.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int CID_W    = 4;
  localparam int PROC_W   = 8;
  localparam int KEY_W    = 16;
  localparam int LOCK_BIT = 31;
  localparam int CID_LSB  = 8;
  localparam int KEY_LSB  = 16;

  localparam logic [ADDR_W-1:0] RLOCK_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] IRQ_BASE   = 8'h40;
  localparam logic [ADDR_W-1:0] BULK_ADDR  = 8'h7E;
  localparam logic [ADDR_W-1:0] KEY_ADDR   = 8'h7F;

  typedef enum logic [1:0] {
    IRQ_EN  = 2'd0,
    IRQ_CLR = 2'd1,
    IRQ_RAW = 2'd2,
    IRQ_MSK = 2'd3
  } irq_sub_e;

  typedef struct packed {
    logic              locked;
    logic [CID_W-1:0]  owner;
    logic [PROC_W-1:0] proc;
  } sem_state_t;

  function automatic logic [REG_W-1:0] sem_word(sem_state_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[LOCK_BIT] = s.locked;
    w[CID_LSB +: CID_W] = s.owner;
    w[PROC_W-1:0] = s.proc;
    return w;
  endfunction
endpackage

// File: rtl/hsem_slot.sv
module hsem_slot
  import hsem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              wr_free,
  input  logic              rd_lock,
  input  logic [CID_W-1:0]  req_cid,
  input  logic [PROC_W-1:0] req_proc,
  input  logic              bulk_hit,
  input  logic [CID_W-1:0]  bulk_cid,
  output sem_state_t        state,
  output logic              freed
);
  sem_state_t nxt;

  always_comb begin
    nxt   = state;
    freed = 1'b0;
    if (state.locked) begin
      if ((wr_free && req_cid == state.owner && req_proc == state.proc) ||
          (bulk_hit && bulk_cid == state.owner)) begin
        nxt   = '0;
        freed = 1'b1;
      end
    end else if (wr_lock) begin
      nxt.locked = 1'b1;
      nxt.owner  = req_cid;
      nxt.proc   = req_proc;
    end else if (rd_lock) begin
      nxt.locked = 1'b1;
      nxt.owner  = req_cid;
      nxt.proc   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= nxt;
  end
endmodule

// File: rtl/hsem_irq_bank.sv
module hsem_irq_bank
  import hsem_pkg::*;
#(
  parameter int N_SEM    = 32,
  parameter int CORE_IDX = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_we,
  input  logic                        clr_we,
  input  logic [N_SEM-1:0]            wdata,
  input  logic [N_SEM-1:0]            freed,
  input  logic [N_SEM-1:0][CID_W-1:0] owner,
  output logic [N_SEM-1:0]            en_q,
  output logic [N_SEM-1:0]            raw_q,
  output logic [N_SEM-1:0]            masked,
  output logic                        irq
);
  logic [N_SEM-1:0] set_vec;
  logic [N_SEM-1:0] clr_vec;

  for (genvar i = 0; i < N_SEM; i++) begin : g_set
    assign set_vec[i] = freed[i] && (owner[i] != CID_W'(CORE_IDX));
  end

  assign clr_vec = clr_we ? wdata : '0;
  assign masked  = raw_q & en_q;
  assign irq     = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      raw_q <= (raw_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/hsem_unit.sv
module hsem_unit
  import hsem_pkg::*;
#(
  parameter int N_SEM   = 32,
  parameter int N_CORES = 2,
  localparam int CIDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int SIDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [CIDX_W-1:0] req_core,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic [N_CORES-1:0] irq
);
  localparam logic [ADDR_W-1:0] SEM_END   = ADDR_W'(N_SEM);
  localparam logic [ADDR_W-1:0] RLOCK_END = ADDR_W'(int'(RLOCK_BASE) + N_SEM);
  localparam logic [ADDR_W-1:0] IRQ_END   = ADDR_W'(int'(IRQ_BASE) + 4 * N_CORES);

  logic wr_acc, rd_acc;
  logic in_sem, in_alias, in_irq;
  logic [SIDX_W-1:0] sidx;
  logic [ADDR_W-1:0] irq_off;
  logic [CID_W-1:0]  req_cid;
  logic bulk_hit;
  logic [KEY_W-1:0] key_q;

  sem_state_t [N_SEM-1:0]         sem_st;
  logic [N_SEM-1:0]               sem_freed;
  logic [N_SEM-1:0]               sem_locked;
  logic [N_SEM-1:0][CID_W-1:0]    sem_owner;
  logic [N_CORES-1:0][N_SEM-1:0]  irq_en_q;
  logic [N_CORES-1:0][N_SEM-1:0]  irq_raw_q;
  logic [N_CORES-1:0][N_SEM-1:0]  irq_msk;

  assign req_ready = 1'b1;
  assign wr_acc    = req_valid && req_write;
  assign rd_acc    = req_valid && !req_write;
  assign in_sem    = req_addr < SEM_END;
  assign in_alias  = (req_addr >= RLOCK_BASE) && (req_addr < RLOCK_END);
  assign in_irq    = (req_addr >= IRQ_BASE) && (req_addr < IRQ_END);
  assign sidx      = req_addr[SIDX_W-1:0];
  assign irq_off   = req_addr - IRQ_BASE;
  assign req_cid   = CID_W'(req_core);
  assign bulk_hit  = wr_acc && (req_addr == BULK_ADDR) &&
                     (req_wdata[KEY_LSB +: KEY_W] == key_q);

  // Semaphore slots
  for (genvar i = 0; i < N_SEM; i++) begin : g_sem
    logic hit_sem, hit_alias;
    assign hit_sem   = in_sem && (sidx == SIDX_W'(i));
    assign hit_alias = in_alias && (sidx == SIDX_W'(i));

    hsem_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lock  (wr_acc && hit_sem && req_wdata[LOCK_BIT]),
      .wr_free  (wr_acc && hit_sem && !req_wdata[LOCK_BIT]),
      .rd_lock  (rd_acc && hit_alias),
      .req_cid  (req_cid),
      .req_proc (req_wdata[PROC_W-1:0]),
      .bulk_hit (bulk_hit),
      .bulk_cid (req_wdata[CID_LSB +: CID_W]),
      .state    (sem_st[i]),
      .freed    (sem_freed[i])
    );

    assign sem_locked[i] = sem_st[i].locked;
    assign sem_owner[i]  = sem_st[i].owner;
  end

  // Per-core notification banks
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic sel;
    assign sel = in_irq && (irq_off[ADDR_W-1:2] == (ADDR_W-2)'(c));

    hsem_irq_bank #(
      .N_SEM    (N_SEM),
      .CORE_IDX (c)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (wr_acc && sel && irq_off[1:0] == IRQ_EN),
      .clr_we (wr_acc && sel && irq_off[1:0] == IRQ_CLR),
      .wdata  (req_wdata[N_SEM-1:0]),
      .freed  (sem_freed),
      .owner  (sem_owner),
      .en_q   (irq_en_q[c]),
      .raw_q  (irq_raw_q[c]),
      .masked (irq_msk[c]),
      .irq    (irq[c])
    );
  end

  // Key register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 key_q <= '0;
    else if (wr_acc && req_addr == KEY_ADDR)    key_q <= req_wdata[KEY_W-1:0];
  end

  // Read data select
  logic [REG_W-1:0] rdata_d;
  logic [CIDX_W-1:0] irq_core;
  assign irq_core = irq_off[2 +: CIDX_W];

  always_comb begin
    rdata_d = '0;
    if (in_sem) begin
      rdata_d = sem_word(sem_st[sidx]);
    end else if (in_alias) begin
      if (sem_st[sidx].locked) begin
        rdata_d = sem_word(sem_st[sidx]);
      end else begin
        rdata_d[LOCK_BIT] = 1'b1;
        rdata_d[CID_LSB +: CID_W] = req_cid;
      end
    end else if (in_irq) begin
      unique case (irq_sub_e'(irq_off[1:0]))
        IRQ_EN:  rdata_d = REG_W'(irq_en_q[irq_core]);
        IRQ_CLR: rdata_d = '0;
        IRQ_RAW: rdata_d = REG_W'(irq_raw_q[irq_core]);
        IRQ_MSK: rdata_d = REG_W'(irq_msk[irq_core]);
        default: rdata_d = '0;
      endcase
    end else if (req_addr == KEY_ADDR) begin
      rdata_d = REG_W'(key_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/hsem_unit_chk.sv
module hsem_unit_chk
  import hsem_pkg::*;
#(
  parameter int N_SEM   = 32,
  parameter int N_CORES = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic [ADDR_W-1:0]             req_addr,
  input logic                          rsp_valid,
  input logic [REG_W-1:0]              rsp_rdata,
  input logic [N_CORES-1:0]            irq,
  input logic [N_SEM-1:0]              sem_locked,
  input logic [N_SEM-1:0][CID_W-1:0]   sem_owner,
  input logic [N_CORES-1:0][N_SEM-1:0] irq_en_q,
  input logic [N_CORES-1:0][N_SEM-1:0] irq_raw_q
);
  localparam int SIDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1;
  logic alias_rd, sem_rd;
  assign alias_rd = req_valid && !req_write && req_addr >= RLOCK_BASE &&
                    req_addr < ADDR_W'(int'(RLOCK_BASE) + N_SEM);
  assign sem_rd   = req_valid && !req_write && req_addr < ADDR_W'(N_SEM);

  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R10
  no_rsp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_write) |=> !rsp_valid);
  // R10
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  // R4
  alias_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && !sem_locked[req_addr[SIDX_W-1:0]]) |=> rsp_rdata[LOCK_BIT]);
  // R5
  free_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_rd && !sem_locked[req_addr[SIDX_W-1:0]]) |=> (rsp_rdata == '0));

  for (genvar i = 0; i < N_SEM; i++) begin : g_s
    // R3
    held_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sem_locked[i] && !(req_valid && req_write)) |=> sem_locked[i]);
    for (genvar c = 0; c < N_CORES; c++) begin : g_c
      // R8
      free_notifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_locked[i] && sem_owner[i] != CID_W'(c)) |=> (sem_locked[i] || irq_raw_q[c][i]));
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_i
    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_q[c] == '0) |-> !irq[c]);
  end
endmodule

bind hsem_unit hsem_unit_chk #(.N_SEM(N_SEM), .N_CORES(N_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .irq        (irq),
  .sem_locked (sem_locked),
  .sem_owner  (sem_owner),
  .irq_en_q   (irq_en_q),
  .irq_raw_q  (irq_raw_q)
);

// File: tb/hsem_unit_bench.sv
module hsem_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [0:0]  req_core = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hsem_unit u_hsem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_core(req_core), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(int core, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_core = core[0:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(int core, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_core = core[0:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    check("R10 rsp_valid after read", 32'(rsp_valid), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'd0);
    check("R10 ready", 32'(req_ready), 32'd1);
    for (int i = 0; i < 32; i++) begin
      rd(0, 8'(i), d);
      check("R1 semaphore free", d, 32'h0);
    end
    rd(0, 8'h40, d); check("R1 enable core0", d, 0);
    rd(1, 8'h46, d); check("R1 raw core1", d, 0);
    rd(0, 8'h7F, d); check("R1 key", d, 0);
  endtask

  task automatic t_two_step();
    logic [31:0] d;
    wr(0, 8'h03, 32'h8000_0012);
    check("R10 no rsp after write", 32'(rsp_valid), 0);
    rd(0, 8'h03, d); check("R2 two-step win", d, 32'h8000_0012);
    wr(1, 8'h03, 32'h8000_0034);
    rd(1, 8'h03, d); check("R3 write lock on taken", d, 32'h8000_0012);
  endtask

  task automatic t_read_lock();
    logic [31:0] d;
    rd(1, 8'h25, d); check("R4 read-lock grant", d, 32'h8000_0100);
    rd(0, 8'h05, d); check("R4 sem word after read-lock", d, 32'h8000_0100);
    rd(0, 8'h25, d); check("R4 read-lock taken returns owner", d, 32'h8000_0100);
    rd(0, 8'h05, d); check("R3 read-lock on taken unchanged", d, 32'h8000_0100);
  endtask

  task automatic t_release_irq();
    logic [31:0] d;
    wr(0, 8'h40, 32'h0000_0020);
    wr(0, 8'h05, 32'h0000_0000);
    rd(0, 8'h05, d); check("R5 wrong core release ignored", d, 32'h8000_0100);
    wr(1, 8'h05, 32'h0000_0001);
    rd(0, 8'h05, d); check("R5 wrong proc release ignored", d, 32'h8000_0100);
    check("R9 irq stays low", 32'(irq), 0);
    wr(1, 8'h05, 32'h0000_0000);
    check("R9 irq core0 raised", 32'(irq), 32'd1);
    rd(0, 8'h05, d); check("R5 released reads zero", d, 0);
    rd(0, 8'h42, d); check("R8 raw core0", d, 32'h20);
    rd(0, 8'h43, d); check("R9 masked core0", d, 32'h20);
    rd(1, 8'h46, d); check("R8 owner core gets no status", d, 0);
    wr(0, 8'h41, 32'h0000_0020);
    rd(0, 8'h42, d); check("R8 w1c clears raw", d, 0);
    rd(0, 8'h41, d); check("R8 clear reads zero", d, 0);
    check("R9 irq cleared", 32'(irq), 0);
    wr(0, 8'h03, 32'h0000_0012);
    rd(1, 8'h46, d); check("R8 raw core1", d, 32'h8);
    rd(1, 8'h47, d); check("R9 masked without enable", d, 0);
    check("R9 irq core1 low", 32'(irq), 0);
  endtask

  task automatic t_key_bulk();
    logic [31:0] d;
    wr(0, 8'h7F, 32'hFFFF_BEEF);
    rd(1, 8'h7F, d); check("R6 key readback", d, 32'h0000_BEEF);
    wr(0, 8'h45, 32'hFFFF_FFFF);
    wr(0, 8'h41, 32'hFFFF_FFFF);
    wr(0, 8'h01, 32'h8000_0001);
    rd(0, 8'h22, d); check("R4 read-lock core0", d, 32'h8000_0000);
    wr(1, 8'h04, 32'h8000_0007);
    wr(1, 8'h7E, 32'h1234_0000);
    rd(0, 8'h01, d); check("R7 wrong key no effect", d, 32'h8000_0001);
    wr(1, 8'h7E, 32'hBEEF_0000);
    rd(0, 8'h01, d); check("R7 bulk frees sem1", d, 0);
    rd(0, 8'h02, d); check("R7 bulk frees sem2", d, 0);
    rd(0, 8'h04, d); check("R7 other owner kept", d, 32'h8000_0107);
    rd(1, 8'h46, d); check("R8 bulk status core1", d, 32'h6);
    rd(0, 8'h42, d); check("R8 bulk none for owner", d, 0);
    wr(0, 8'h7E, 32'hBEEF_0100);
    rd(0, 8'h04, d); check("R7 bulk core1", d, 0);
    rd(0, 8'h42, d); check("R8 bulk status core0", d, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_step();
    t_read_lock();
    t_release_irq();
    t_key_bulk();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule